// File: doc/BRIEF.md
# Convolution Tap-Mask Sharing Analyzer

This block inspects a programmable 3x3 convolution coefficient mask and works out how a convolution datapath can share multipliers across it. After a start request it captures the nine signed coefficients and scans them one position per clock in row-major order. It builds a table of the distinct coefficient values and gives every position a group index that points into that table. It also reports how many distinct values the mask holds.

From the distinct count it derives how many output pixels can be produced in parallel from a fixed pool of multipliers. That pool has 18 multipliers by default. The lane count is the pool size divided by the distinct count, rounded down. A datapath reads the group indices, value slots and lane count once the done flag is raised. These results stay frozen until the next accepted start.

Top module: `tca_analyzer`

## Requirements
- R1: When done is high, the distinct count equals the number of different coefficient values in the captured mask. It lies between 1 and 9.
- R2: A zero coefficient is a value of its own. A mask whose three rows are each -1 0 +1 reports 3 distinct values.
- R3: Value slot k holds the k-th distinct value in order of first appearance. Positions are scanned row-major: position p = 3*row + col, whose coefficient sits at mask bits [9p+8:9p]. Slot k is at slot bits [9k+8:9k], and slots at or beyond the distinct count read zero.
- R4: The group index of position p sits at group bits [4p+3:4p]. It names the slot that holds position p's coefficient, so it is always below the distinct count.
- R5: The lane count is 18, 9, 6, 4, 3, 3, 2, 2, 2 for 1 to 9 distinct values. This equals floor(18 / distinct).
- R6: A start sampled while idle captures the mask and raises busy on the next cycle. Done rises 9 clock edges after the capture edge, in the same edge on which busy falls. Busy and done are never high together.
- R7: A start seen while busy is ignored. The results and the done timing follow the mask captured at the accepted start.
- R8: While idle after a run, the group indices, slots, distinct count and done stay unchanged when the mask input changes, until the next accepted start.
- R9: After reset, busy, done, distinct count and lane count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to capture the mask and analyze it |
| mask_i | input | 81 | Nine 9-bit signed coefficients, position p at bits [9p+8:9p] |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Results valid; held until the next accepted start |
| distinct_o | output | 4 | Number of distinct coefficient values |
| lanes_o | output | 5 | Output pixels computable in parallel |
| group_o | output | 36 | Per-position slot index, position p at bits [4p+3:4p] |
| slot_o | output | 81 | Distinct values, slot k at bits [9k+8:9k] |

## Verification
The bench targets zero handling: a design that treats zero as "no tap" would report 2 instead of 3 for the derivative mask. It also sweeps every distinct count from 1 to 9, which shows where a lane table is off by one entry (for example 4 for five values). Masks with full-range extremes (-256 and 255) and with a late first appearance check slot ordering and the signed comparison; a wrong ordering would misplace slots and corrupt group indices. Finally, a second start during a scan and a changing mask input after completion would, in a design lacking the guard, restart the run or disturb results that a datapath is reading.

// File: rtl/tca_pkg.sv
// Package: shared types for the tap-mask sharing analyzer.
// Assumes: nothing beyond standard SystemVerilog.
package tca_pkg;

    // Sequencer states: waiting for start, or scanning positions
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } tca_state_e;

endpackage

// File: rtl/tca_ctrl.sv
// tca_ctrl: sequences one analysis run.
// It accepts a start only while idle, steps a position index once per
// clock, and raises done after the last position.
// Assumes: NPOS >= 2; start is ignored while a scan is running.
module tca_ctrl
    import tca_pkg::*;
#(
    parameter int NPOS = 9,
    parameter int GW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          accept_o,
    output logic          step_o,
    output logic [GW-1:0] idx_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam logic [GW-1:0] LAST_IDX = GW'(NPOS - 1);

    tca_state_e    state_q;
    logic [GW-1:0] idx_q;
    logic          done_q;

    // Start is honoured only when no scan is running
    assign accept_o = (state_q == ST_IDLE) && start_i;
    assign step_o   = (state_q == ST_SCAN);
    assign idx_o    = idx_q;
    assign busy_o   = (state_q == ST_SCAN);
    assign done_o   = done_q;

    // State, position counter and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_SCAN;
                        idx_q   <= '0;
                        done_q  <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= ST_IDLE;
                        idx_q   <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tca_slot_match.sv
// tca_slot_match: compares one coefficient against every filled slot at once.
// Reports whether a match exists and the lowest matching slot index.
// Assumes: slots at or beyond count are not valid and are masked out.
module tca_slot_match #(
    parameter int NPOS = 9,
    parameter int CW   = 9,
    parameter int GW   = 4,
    parameter int NW   = 4
) (
    input  logic [NPOS*CW-1:0] slots_i,
    input  logic [NW-1:0]      count_i,
    input  logic [CW-1:0]      coef_i,
    output logic               hit_o,
    output logic [GW-1:0]      hit_idx_o
);

    logic [NPOS-1:0] eq;

    // One comparator per slot, qualified by slot occupancy
    for (genvar k = 0; k < NPOS; k++) begin : g_cmp
        assign eq[k] = (NW'(k) < count_i) && (slots_i[k*CW +: CW] == coef_i);
    end

    assign hit_o = |eq;

    // Lowest matching slot wins
    always_comb begin
        hit_idx_o = '0;
        for (int k = NPOS - 1; k >= 0; k--) begin
            if (eq[k]) hit_idx_o = GW'(k);
        end
    end

endmodule

// File: rtl/tca_lane_lut.sv
// tca_lane_lut: maps a distinct-value count to the number of parallel
// output lanes a fixed multiplier pool supports (pool / count, floored).
// Assumes: count 0 means no result yet and yields 0 lanes.
module tca_lane_lut #(
    parameter int NPOS = 9,
    parameter int POOL = 18,
    parameter int NW   = 4,
    parameter int LW   = 5
) (
    input  logic [NW-1:0] count_i,
    output logic [LW-1:0] lanes_o
);

    logic [LW-1:0] tbl [NPOS+1];

    // Constant table, one entry per possible count
    for (genvar n = 0; n <= NPOS; n++) begin : g_tbl
        localparam int LANES = (n == 0) ? 0 : (POOL / n);
        assign tbl[n] = LW'(LANES);
    end

    // Select the entry; out-of-range counts map to zero
    always_comb begin
        lanes_o = '0;
        if (count_i <= NW'(NPOS)) lanes_o = tbl[count_i];
    end

endmodule

// File: rtl/tca_map_store.sv
// tca_map_store: holds the captured mask, the distinct-value slots, the
// per-position group indices and the distinct count.
// On accept it captures the mask and clears all results; on each step it
// files the current position either into a matching slot or a new one.
// Assumes: step and accept are never high together.
module tca_map_store #(
    parameter int NPOS = 9,
    parameter int CW   = 9,
    parameter int GW   = 4,
    parameter int NW   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept_i,
    input  logic               step_i,
    input  logic [GW-1:0]      idx_i,
    input  logic [NPOS*CW-1:0] mask_i,
    input  logic               hit_i,
    input  logic [GW-1:0]      hit_idx_i,
    output logic [CW-1:0]      coef_o,
    output logic [NPOS*CW-1:0] slots_o,
    output logic [NPOS*GW-1:0] groups_o,
    output logic [NW-1:0]      count_o
);

    logic [NPOS*CW-1:0] mask_q;
    logic [CW-1:0]      slot_q  [NPOS];
    logic [GW-1:0]      group_q [NPOS];
    logic [NW-1:0]      count_q;

    // Coefficient of the position being scanned
    assign coef_o  = mask_q[int'(idx_i)*CW +: CW];
    assign count_o = count_q;

    // Captured copy of the mask, taken only on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else if (accept_i) mask_q <= mask_i;
    end

    // Slot table, group indices and distinct count
    always_ff @(posedge clk) begin
        if (!rst_n || accept_i) begin
            count_q <= '0;
            for (int k = 0; k < NPOS; k++) begin
                slot_q[k]  <= '0;
                group_q[k] <= '0;
            end
        end else if (step_i) begin
            if (hit_i) begin
                group_q[idx_i] <= hit_idx_i;
            end else if (count_q < NW'(NPOS)) begin
                group_q[idx_i]             <= count_q[GW-1:0];
                slot_q[count_q[GW-1:0]]    <= coef_o;
                count_q                    <= count_q + 1'b1;
            end
        end
    end

    // Flatten the tables onto output buses
    for (genvar k = 0; k < NPOS; k++) begin : g_flat
        assign slots_o[k*CW +: CW]  = slot_q[k];
        assign groups_o[k*GW +: GW] = group_q[k];
    end

endmodule

// File: rtl/tca_analyzer.sv
// tca_analyzer: top of the tap-mask sharing analyzer.
// Captures a KDIM x KDIM signed coefficient mask on start, scans it one
// position per clock, and reports distinct values, group indices, the
// distinct count and the parallel lane count for a POOL-multiplier array.
// Assumes: results are read only while done is high.
module tca_analyzer #(
    parameter int KDIM = 3,
    parameter int CW   = 9,
    parameter int POOL = 18,
    localparam int NPOS = KDIM * KDIM,
    localparam int GW   = $clog2(NPOS),
    localparam int NW   = $clog2(NPOS + 1),
    localparam int LW   = $clog2(POOL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [NPOS*CW-1:0] mask_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [NW-1:0]      distinct_o,
    output logic [LW-1:0]      lanes_o,
    output logic [NPOS*GW-1:0] group_o,
    output logic [NPOS*CW-1:0] slot_o
);

    logic          accept;
    logic          step;
    logic [GW-1:0] idx;
    logic [CW-1:0] coef;
    logic          hit;
    logic [GW-1:0] hit_idx;
    logic [NW-1:0] count;

    tca_ctrl #(.NPOS(NPOS), .GW(GW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .step_o   (step),
        .idx_o    (idx),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    tca_map_store #(.NPOS(NPOS), .CW(CW), .GW(GW), .NW(NW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .step_i    (step),
        .idx_i     (idx),
        .mask_i    (mask_i),
        .hit_i     (hit),
        .hit_idx_i (hit_idx),
        .coef_o    (coef),
        .slots_o   (slot_o),
        .groups_o  (group_o),
        .count_o   (count)
    );

    tca_slot_match #(.NPOS(NPOS), .CW(CW), .GW(GW), .NW(NW)) u_match (
        .slots_i   (slot_o),
        .count_i   (count),
        .coef_i    (coef),
        .hit_o     (hit),
        .hit_idx_o (hit_idx)
    );

    tca_lane_lut #(.NPOS(NPOS), .POOL(POOL), .NW(NW), .LW(LW)) u_lanes (
        .count_i (count),
        .lanes_o (lanes_o)
    );

    assign distinct_o = count;

endmodule

// File: rtl/tca_checker.sv
// tca_checker: temporal properties of tca_analyzer, attached by bind.
// Assumes: synchronous active-low reset; all inputs are top-level ports.
module tca_checker #(
    parameter int NPOS = 9,
    parameter int POOL = 18,
    parameter int GW   = 4,
    parameter int NW   = 4,
    parameter int LW   = 5,
    parameter int CW   = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy_o,
    input logic               done_o,
    input logic [NW-1:0]      distinct_o,
    input logic [LW-1:0]      lanes_o,
    input logic [NPOS*GW-1:0] group_o,
    input logic [NPOS*CW-1:0] slot_o
);

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (distinct_o >= NW'(1)) && (distinct_o <= NW'(NPOS))); // R1
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && $past(busy_o)) |-> ((distinct_o == $past(distinct_o)) || (distinct_o == $past(distinct_o) + 1'b1))); // R1
    AST_LANES_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> ((int'(lanes_o) * int'(distinct_o) <= POOL) && ((int'(lanes_o) + 1) * int'(distinct_o) > POOL))); // R5
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy_o && done_o)); // R6
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> done_o); // R6
    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n) (done_o && $past(done_o)) |-> ($stable(group_o) && $stable(slot_o) && $stable(distinct_o))); // R8

    for (genvar p = 0; p < NPOS; p++) begin : g_grp
        AST_GROUP_RANGE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (NW'(group_o[p*GW +: GW]) < distinct_o)); // R4
    end

endmodule

bind tca_analyzer tca_checker #(
    .NPOS(NPOS), .POOL(POOL), .GW(GW), .NW(NW), .LW(LW), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .distinct_o (distinct_o),
    .lanes_o    (lanes_o),
    .group_o    (group_o),
    .slot_o     (slot_o)
);

// File: tb/tb_tca_analyzer.sv
// tb_tca_analyzer: directed bench for the tap-mask sharing analyzer.
module tb_tca_analyzer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [80:0] mask_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [3:0]  distinct_o;
    logic [4:0]  lanes_o;
    logic [35:0] group_o;
    logic [80:0] slot_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    tca_analyzer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mask_i     (mask_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .distinct_o (distinct_o),
        .lanes_o    (lanes_o),
        .group_o    (group_o),
        .slot_o     (slot_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // One check; prints a FAIL line on mismatch
    task automatic chk(input bit ok, input string req, input logic [80:0] act, input logic [80:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [80:0] mk(input int a0, input int a1, input int a2,
                                       input int a3, input int a4, input int a5,
                                       input int a6, input int a7, input int a8);
        logic [80:0] m;
        m[8:0] = a0[8:0];   m[17:9] = a1[8:0];  m[26:18] = a2[8:0];
        m[35:27] = a3[8:0]; m[44:36] = a4[8:0]; m[53:45] = a5[8:0];
        m[62:54] = a6[8:0]; m[71:63] = a7[8:0]; m[80:72] = a8[8:0];
        return m;
    endfunction

    // Expected results from the requirements: first-appearance slots
    task automatic model(input logic [80:0] m, output int cnt,
                         output logic [35:0] g, output logic [80:0] s);
        cnt = 0; g = '0; s = '0;
        for (int p = 0; p < 9; p++) begin
            int found;
            found = -1;
            for (int k = 0; k < cnt; k++)
                if (found < 0 && s[k*9 +: 9] == m[p*9 +: 9]) found = k;
            if (found < 0) begin
                s[cnt*9 +: 9] = m[p*9 +: 9];
                found = cnt;
                cnt++;
            end
            g[p*4 +: 4] = 4'(found);
        end
    endtask

    // Raise start for one cycle; returns just after the capture edge
    task automatic launch(input logic [80:0] m);
        @(negedge clk);
        mask_i  = m;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        repeat (9) @(negedge clk);
    endtask

    task automatic check_result(input logic [80:0] m, input string req);
        int cnt;
        logic [35:0] g;
        logic [80:0] s;
        model(m, cnt, g, s);
        chk(done_o === 1'b1, {req, " done"}, 81'(done_o), 81'(1));
        chk(distinct_o === 4'(cnt), {req, " R1 distinct"}, 81'(distinct_o), 81'(cnt));
        chk(lanes_o === 5'(18 / cnt), {req, " R5 lanes"}, 81'(lanes_o), 81'(18 / cnt));
        chk(group_o === g, {req, " R4 groups"}, 81'(group_o), 81'(g));
        chk(slot_o === s, {req, " R3 slots"}, slot_o, s);
    endtask

    task automatic run_and_check(input logic [80:0] m, input string req);
        launch(m);
        wait_done();
        check_result(m, req);
    endtask

    task automatic t_reset();
        chk(busy_o === 1'b0, "R9 busy", 81'(busy_o), 81'(0));
        chk(done_o === 1'b0, "R9 done", 81'(done_o), 81'(0));
        chk(distinct_o === 4'd0, "R9 distinct", 81'(distinct_o), 81'(0));
        chk(lanes_o === 5'd0, "R9 lanes", 81'(lanes_o), 81'(0));
    endtask

    task automatic t_uniform();
        run_and_check(mk(5, 5, 5, 5, 5, 5, 5, 5, 5), "R1 uniform");
        chk(distinct_o === 4'd1, "R1 uniform count", 81'(distinct_o), 81'(1));
    endtask

    task automatic t_centre();
        run_and_check(mk(3, 3, 3, 3, -7, 3, 3, 3, 3), "R1 centre");
        chk(distinct_o === 4'd2, "R1 centre count", 81'(distinct_o), 81'(2));
    endtask

    task automatic t_zero();
        run_and_check(mk(-1, 0, 1, -1, 0, 1, -1, 0, 1), "R2 zero");
        chk(distinct_o === 4'd3, "R2 zero count", 81'(distinct_o), 81'(3));
        chk(lanes_o === 5'd6, "R2 zero lanes", 81'(lanes_o), 81'(6));
    endtask

    task automatic t_derivative();
        run_and_check(mk(-1, -2, -1, 0, 0, 0, 1, 2, 1), "R2 derivative");
        chk(distinct_o === 4'd5, "R2 derivative count", 81'(distinct_o), 81'(5));
        chk(slot_o[44:0] === {9'd2, 9'd1, 9'd0, 9'h1FE, 9'h1FF}, "R3 derivative order",
            81'(slot_o[44:0]), 81'({9'd2, 9'd1, 9'd0, 9'h1FE, 9'h1FF}));
    endtask

    task automatic t_extremes();
        run_and_check(mk(255, -256, 0, 1, -1, 100, -100, 254, -255), "R3 extremes");
        run_and_check(mk(7, 7, 7, 7, 7, 7, 7, 7, -256), "R3 late appearance");
    endtask

    task automatic t_sweep();
        for (int n = 1; n <= 9; n++) begin
            logic [80:0] m;
            for (int p = 0; p < 9; p++) m[p*9 +: 9] = 9'((p % n) * 7 - 20);
            run_and_check(m, $sformatf("R5 sweep n=%0d", n));
        end
    endtask

    task automatic t_timing();
        launch(mk(1, 2, 3, 4, 5, 6, 7, 8, 9));
        chk(busy_o === 1'b1, "R6 busy after capture", 81'(busy_o), 81'(1));
        repeat (8) @(negedge clk);
        chk(done_o === 1'b0, "R6 done not early", 81'(done_o), 81'(0));
        chk(busy_o === 1'b1, "R6 busy still", 81'(busy_o), 81'(1));
        @(negedge clk);
        chk(done_o === 1'b1 && busy_o === 1'b0, "R6 done on time", 81'({busy_o, done_o}), 81'(1));
    endtask

    task automatic t_ignore();
        logic [80:0] a;
        a = mk(4, 4, -4, -4, 0, 0, 4, 4, 4);
        launch(a);
        @(negedge clk);
        mask_i  = mk(9, 8, 7, 6, 5, 4, 3, 2, 1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, "R7 still busy", 81'(busy_o), 81'(1));
        repeat (6) @(negedge clk);
        chk(done_o === 1'b0, "R7 done not early", 81'(done_o), 81'(0));
        @(negedge clk);
        check_result(a, "R7 ignored start");
    endtask

    task automatic t_hold();
        logic [80:0] a;
        a = mk(2, -3, 2, -3, 2, -3, 2, -3, 2);
        run_and_check(a, "R8 base");
        mask_i = mk(11, 12, 13, 14, 15, 16, 17, 18, 19);
        repeat (5) @(negedge clk);
        check_result(a, "R8 held");
        chk(busy_o === 1'b0, "R8 idle", 81'(busy_o), 81'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_uniform();
        t_centre();
        t_zero();
        t_derivative();
        t_extremes();
        t_sweep();
        t_timing();
        t_ignore();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R6 actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule